// File: doc/BRIEF.md
# Four-Channel PWM Control and Status Register Block

This block is the register front end of a four-channel pulse-width modulator. A simple single-cycle read/write port reaches a set of global registers and one register window per channel. Software starts channels through a write-one-to-set enable register and stops them through a separate write-one-to-clear disable register. A status register shows which channels are running. An event register records, per channel, that a new period has begun. Reading it returns what was recorded and clears it in the same access.

Each channel window holds a period register and a read-only count of the current position within the period. A channel block keeps this timebase and signals the start of every period. Waveform shaping, interrupt masking and any richer bus protocol are not part of this block.

Top module: `pwm_ctrl_top`

## Requirements
- R1: After reset no channel runs, the status register (0x0C) and the event register (0x1C) read zero, and every channel period register reads 255.
- R2: A write to offset 0x04 starts channel n for each bit n of wdata[3:0] that is 1; bits that are 0 leave their channel unchanged, and bits above 3 are ignored.
- R3: A write to offset 0x08 stops channel n for each bit n of wdata[3:0] that is 1; bits that are 0 leave their channel unchanged.
- R4: A read of offset 0x0C returns the running state of channel n in bit n of bits [3:0], with all higher bits zero; a channel reads as running from the second clock edge after its start write.
- R5: Bit n of the event register (0x1C) sets when channel n begins a period, and a channel begins its first period in the cycle right after it is started.
- R6: A read of 0x1C returns the recorded event bits and clears all of them; with no read they stay set.
- R7: A period-start event that falls in the same cycle as a read of 0x1C stays recorded for the next read.
- R8: The window of channel n starts at 0x200 + n*0x20; offset +0x00 is a read/write 16-bit period value P held in bits [15:0], and offset +0x04 is a read-only count that advances by one per clock while the channel runs.
- R9: A running channel with period value P begins a new period every P+1 clocks; a stopped channel's count reads zero.
- R10: Reads of unmapped offsets, of the enable and disable registers, and of unused window offsets return zero; writes to unmapped offsets, to 0x0C and to 0x1C change nothing.
- R11: Read data appears on bus_rdata on the clock edge that samples bus_rd and is zero after any edge without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |

## Verification
The embedded properties watch, every cycle, that enable and disable writes set and clear exactly the requested bits, that recorded events persist until a read, that an event arriving with a read survives it, that a read with no new event leaves the register empty, and that unmapped or idle cycles drive zero data. Only the bench scenarios show the period spacing of P+1 clocks, the one-edge lag of the status bits, the window address layout, the count advancing by one per clock, and that writes to read-only or unmapped offsets alter nothing visible.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

  // Global register offsets (byte addresses)
  localparam logic [11:0] OFS_START = 12'h004;
  localparam logic [11:0] OFS_STOP  = 12'h008;
  localparam logic [11:0] OFS_STAT  = 12'h00C;
  localparam logic [11:0] OFS_EVT   = 12'h01C;

  // Channel window layout
  localparam logic [11:0] WIN_BASE  = 12'h200;
  localparam int unsigned WIN_SHIFT = 5;  // 0x20 bytes per window

  // Offset of a byte address inside the channel window region.
  function automatic logic [11:0] win_rel(input logic [11:0] addr);
    return addr - WIN_BASE;
  endfunction

  // True when the address falls in one of nch windows.
  function automatic logic win_hit(input logic [11:0] addr, input int unsigned nch);
    logic [11:0] rel;
    rel = win_rel(addr);
    return (addr >= WIN_BASE) && ((rel >> WIN_SHIFT) < 12'(nch));
  endfunction

  // New event vector after one cycle: a read clears, fresh events survive.
  function automatic logic [31:0] evt_next(input logic [31:0] cur,
                                           input logic [31:0] evt,
                                           input logic        clr);
    return clr ? evt : (cur | evt);
  endfunction

endpackage

// File: rtl/pwmc_chan.sv
module pwmc_chan #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned OFS_W   = 5,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PER_RST = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              wr_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              active_o,
  output logic              start_o
);
  localparam logic [OFS_W-1:0] OFS_PER = '0;
  localparam logic [OFS_W-1:0] OFS_CNT = OFS_W'(4);

  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic             period_end;

  // Named event wires for the checks below
  assign period_end = active_q && (cnt_q >= per_q);
  assign start_o    = run_i && (!active_q || period_end);
  assign active_o   = active_q;

  // R1: reset leaves the channel idle with the default period
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q    <= CNT_W'(PER_RST);
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      active_q <= run_i;
      if (wr_i && ofs_i == OFS_PER) per_q <= wdata_i[CNT_W-1:0];
      if (!run_i || start_o) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8: window read mux, unused offsets read zero (R10)
  always_comb begin
    rdata_o = '0;
    if (ofs_i == OFS_PER)      rdata_o = DATA_W'(per_q);
    else if (ofs_i == OFS_CNT) rdata_o = DATA_W'(cnt_q);
  end

  p_idle_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0 && !active_q));
  p_start_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> active_q);
  p_first_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(start_o));
endmodule

// File: rtl/pwmc_evt.sv
module pwmc_evt #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic              clr_i,
  output logic [NUM_CH-1:0] flags_o
);
  import pwmc_pkg::*;

  logic [NUM_CH-1:0] flags_q;
  logic [31:0]       nxt;

  assign nxt     = evt_next(32'(flags_q), 32'(evt_i), clr_i);
  assign flags_o = flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= nxt[NUM_CH-1:0];
  end

  p_evt_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && evt_i == '0) |=> (flags_q == '0));
endmodule

// File: rtl/pwm_ctrl_top.sv
module pwm_ctrl_top #(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PER_RST = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  import pwmc_pkg::*;

  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned OFS_W = WIN_SHIFT;

  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] chan_active;
  logic [NUM_CH-1:0] chan_start;
  logic [NUM_CH-1:0] evt_flags;
  logic [DATA_W-1:0] chan_rdata [NUM_CH];
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  logic [11:0]      rel;
  logic             in_win;
  logic [IDX_W-1:0] win_idx;
  logic [OFS_W-1:0] win_ofs;
  logic             hit_start, hit_stop, hit_stat, hit_evt, mapped;
  logic             start_wr, stop_wr, evt_rd;

  // Address decode
  assign rel       = win_rel(12'(bus_addr));
  assign in_win    = win_hit(12'(bus_addr), NUM_CH);
  assign win_idx   = rel[WIN_SHIFT +: IDX_W];
  assign win_ofs   = rel[OFS_W-1:0];
  assign hit_start = (12'(bus_addr) == OFS_START);
  assign hit_stop  = (12'(bus_addr) == OFS_STOP);
  assign hit_stat  = (12'(bus_addr) == OFS_STAT);
  assign hit_evt   = (12'(bus_addr) == OFS_EVT);
  assign mapped    = hit_stat || hit_evt || in_win;
  assign start_wr  = bus_wr && hit_start;
  assign stop_wr   = bus_wr && hit_stop;
  assign evt_rd    = bus_rd && hit_evt;

  // R2/R3: write-one-to-set and write-one-to-clear run bits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (start_wr) begin
      en_q <= en_q | bus_wdata[NUM_CH-1:0];
    end else if (stop_wr) begin
      en_q <= en_q & ~bus_wdata[NUM_CH-1:0];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic wr_sel;
    assign wr_sel = bus_wr && in_win && (win_idx == IDX_W'(g));
    pwmc_chan #(
      .CNT_W  (CNT_W),
      .OFS_W  (OFS_W),
      .DATA_W (DATA_W),
      .PER_RST(PER_RST)
    ) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (en_q[g]),
      .wr_i    (wr_sel),
      .ofs_i   (win_ofs),
      .wdata_i (bus_wdata),
      .rdata_o (chan_rdata[g]),
      .active_o(chan_active[g]),
      .start_o (chan_start[g])
    );
  end

  pwmc_evt #(.NUM_CH(NUM_CH)) u_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (chan_start),
    .clr_i  (evt_rd),
    .flags_o(evt_flags)
  );

  // R4/R6/R8/R10: read mux
  always_comb begin
    rd_mux = '0;
    if (hit_stat)     rd_mux = DATA_W'(chan_active);
    else if (hit_evt) rd_mux = DATA_W'(evt_flags);
    else if (in_win)  rd_mux = chan_rdata[win_idx];
  end

  // R11: registered read data
  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= bus_rd ? rd_mux : '0;
  end
  assign bus_rdata = rdata_q;

  p_start_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> ((en_q & $past(bus_wdata[NUM_CH-1:0])) == $past(bus_wdata[NUM_CH-1:0])));
  p_start_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> ((en_q & $past(en_q)) == $past(en_q)));
  p_stop_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> ((en_q & $past(bus_wdata[NUM_CH-1:0])) == '0));
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !mapped) |=> (bus_rdata == '0));
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));
  p_stat_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit_stat) |=> (bus_rdata[DATA_W-1:NUM_CH] == '0));
endmodule

// File: tb/tb_pwm_ctrl_top.sv
module tb_pwm_ctrl_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [11:0] A_START = 12'h004, A_STOP = 12'h008,
                          A_STAT = 12'h00C, A_EVT = 12'h01C;

  pwm_ctrl_top dut (.*);

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [11:0] per_addr(input int ch);
    return 12'h200 + 12'(ch * 32);
  endfunction
  function automatic logic [11:0] cnt_addr(input int ch);
    return 12'h204 + 12'(ch * 32);
  endfunction
  function automatic logic [3:0] apply_mask(input logic [3:0] cur, input logic [3:0] m,
                                            input logic set);
    return set ? (cur | m) : (cur & ~m);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Leaves bus_rd asserted so that reads can run back to back.
  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    #1 d = bus_rdata;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [31:0] d, d2;
    logic [3:0]  m_en;
    logic [15:0] m_per [4];
    int          hits [$];
    void'($urandom(32'h5eed_0042));

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    rd(A_STAT, d); check("R1 status", d, 0);
    rd(A_EVT, d);  check("R1 events", d, 0);
    for (int c = 0; c < 4; c++) begin
      rd(per_addr(c), d); check("R1 period", d, 32'd255);
      m_per[c] = 16'd255;
    end
    idle();
    m_en = '0;

    // R2/R3/R4/R8: constrained random enables, disables and period writes
    for (int i = 0; i < 30; i++) begin
      int op;
      op = int'($urandom % 3);
      if (op == 0 || op == 1) begin
        logic [31:0] v;
        v = $urandom;
        wr(op == 0 ? A_START : A_STOP, v);
        m_en = apply_mask(m_en, v[3:0], op == 0);
        rd(A_STAT, d); idle();
        check(op == 0 ? "R2 start mask" : "R3 stop mask", d, 32'(m_en));
        check("R4 status", d, 32'(m_en));
      end else begin
        int c;
        logic [15:0] p;
        c = int'($urandom % 4);
        p = 16'(($urandom % 4000) + 50);
        wr(per_addr(c), {16'hABCD, p});
        m_per[c] = p;
        rd(per_addr(c), d); idle();
        check("R8 period readback", d, 32'(p));
      end
    end

    // R10: unmapped and write-only offsets
    wr(A_STOP, 32'hF); m_en = '0;
    foreach (m_per[c]) begin
      rd(per_addr(c), d); check("R10 period intact before", d, 32'(m_per[c]));
    end
    rd(12'h000, d); check("R10 unmapped 0x000", d, 0);
    rd(A_START, d); check("R10 start reads zero", d, 0);
    rd(A_STOP, d);  check("R10 stop reads zero", d, 0);
    rd(12'h010, d); check("R10 unmapped 0x010", d, 0);
    rd(12'h20C, d); check("R10 unused window offset", d, 0);
    rd(12'h280, d); check("R10 beyond last window", d, 0);
    idle();
    wr(A_STAT, 32'hF);
    rd(A_STAT, d); idle(); check("R10 status write ignored", d, 0);
    wr(12'h280, 32'h1234); wr(12'h100, 32'h77);
    foreach (m_per[c]) begin
      rd(per_addr(c), d); check("R10 period intact after", d, 32'(m_per[c]));
    end
    idle();

    // R5/R6: first period event, clear on read, write to event register ignored
    rd(A_EVT, d); idle();
    wr(per_addr(2), 32'd2000);
    wr(A_START, 32'h4);
    repeat (3) @(posedge clk);
    wr(A_EVT, 32'hF);
    rd(A_EVT, d);  check("R5 start event", d, 32'h4);
    rd(A_EVT, d2); idle(); check("R6 cleared by read", d2, 0);
    rd(cnt_addr(2), d);
    rd(cnt_addr(2), d2); idle();
    check("R8 count advances", d2 - d, 1);
    wr(A_STOP, 32'h4);
    rd(cnt_addr(2), d); idle(); check("R9 stopped count zero", d, 0);

    // R9: spacing of period events for P = 9
    wr(per_addr(1), 32'd9);
    rd(A_EVT, d); idle();
    wr(A_START, 32'h2);
    for (int k = 0; k < 45; k++) begin
      rd(A_EVT, d);
      if (d[1]) hits.push_back(k);
    end
    idle();
    check("R9 hit count", 32'(hits.size()), 5);
    for (int k = 1; k < hits.size(); k++)
      check("R9 period spacing", 32'(hits[k] - hits[k-1]), 10);
    check("R5 first hit on first read", 32'(hits[0]), 0);
    wr(A_STOP, 32'h2);

    // R7: event every cycle with back-to-back reads
    wr(per_addr(0), 32'd0);
    rd(A_EVT, d); idle();
    wr(A_START, 32'h1);
    for (int k = 0; k < 5; k++) begin
      rd(A_EVT, d);
      check("R7 coincident event kept", 32'(d[0]), 1);
    end
    idle();

    // R11: idle cycles drive zero
    @(negedge clk);
    check("R11 idle rdata", bus_rdata, 0);
    wr(A_STOP, 32'hF);
    rd(A_STAT, d); idle(); check("R4 all stopped", d, 0);

    summary();
  end
endmodule